// File: doc/BRIEF.md
# Receive Queue with Character and Block Error Status

This block is the receive-side holding queue of one serial channel. A serial receiver placed in front of it hands over each finished character as a strobe carrying the data byte and three line-condition flags: break seen, bad stop bit (framing) and bad parity. The queue keeps up to `DEPTH` characters, each stored together with its own flags. The CPU takes them out in arrival order through a read strobe.

The block also builds the channel status byte. The three error bits can follow one of two policies, chosen by a mode input. In per-character mode they show the flags of the character waiting at the head of the queue. In block mode they show a running OR of the flags of every character that has entered the queue since the last error clear. The OR is taken as characters enter, so a bad byte is reported at once even when good bytes are queued ahead of it. The status byte also carries a sticky overrun bit and the queue occupancy.

For flow control, the block can raise an active-low request-to-send output. It does this when a start bit is detected while every slot is taken, so the remote transmitter stops before an overrun occurs. The output drops again once the CPU frees a slot.

Top module: `rx_err_fifo`

## Requirements
- R1: Each accepted character is stored with its break, framing and parity flags. Reads return bytes in arrival order, and `rd_data` takes the head byte on the clock edge that samples `rd_stb`.
- R2: With `blk_mode`=0, `stat[7:5]` = {break, framing, parity} of the character at the head, and 3'b000 when the queue is empty.
- R3: With `blk_mode`=1, `stat[7:5]` is the OR of the flags of all characters accepted since the last error clear or receiver reset. It is visible the cycle after acceptance and stays set after the queue drains.
- R4: `err_clr` clears the accumulated flags and the overrun bit. A character accepted in the same cycle still contributes its flags to the accumulated value.
- R5: `rx_rst` empties the queue and clears the accumulated flags, the overrun bit and `rtsn`, taking priority over a write in the same cycle, so `stat` reads 8'h00 afterwards.
- R6: Status layout, bit 7 down to bit 0: break, framing, parity, overrun, 0, 0, full, ready. The two transmitter positions read 0.
- R7: `stat[0]` (ready) is 1 while at least one character is held. `stat[1]` (full) is 1 while all `DEPTH` slots are held.
- R8: A character strobed while the queue is full is discarded and sets `stat[4]` (overrun). The bit stays set until `err_clr` or `rx_rst`.
- R9: With `auto_rts`=1, `start_det` while full drives `rtsn` to 1 on the next edge. `start_det` while not full leaves `rtsn` at 0.
- R10: `rtsn` returns to 0 on the first edge at which the queue is no longer full (one edge after the edge that frees a slot), and at once on the edge after `auto_rts` goes low.
- R11: A read strobe on an empty queue leaves `rd_data` and the queue pointers unchanged. The next written byte is the next one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rx_rst | input | 1 | Synchronous receiver reset command |
| err_clr | input | 1 | Error-clear command (accumulated flags and overrun) |
| blk_mode | input | 1 | 1 = block error accumulation, 0 = per-character status |
| auto_rts | input | 1 | Enables automatic request-to-send negation |
| chr_vld | input | 1 | Received-character strobe |
| chr_data | input | DATA_W | Received byte |
| chr_brk | input | 1 | Break flag of the received character |
| chr_fe | input | 1 | Framing-error flag of the received character |
| chr_pe | input | 1 | Parity-error flag of the received character |
| start_det | input | 1 | Pulse: a valid start bit was detected |
| rd_stb | input | 1 | CPU read strobe |
| rd_data | output | DATA_W | Last byte read from the queue |
| stat | output | 8 | Channel status byte |
| rtsn | output | 1 | Active-low request-to-send, 1 = hold off the sender |

## Verification
A wrong pointer or count shows within one read. The byte returned differs from the arrival order, or the ready/full bits disagree with the number of characters written, so every fill and drain is compared byte by byte. A lost or wrongly cleared accumulator stays hidden in per-character mode. The bench therefore switches modes while the head holds a clean byte and a later byte holds an error, which exposes the difference in the same cycle. It also drains the queue to confirm the error stays sticky. The request-to-send register is probed on the exact edge it should rise and on the exact edge it should fall, because an off-by-one in its release would pass a check made only at the end.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
   // per-character line condition flags, msb first as seen in status
   typedef struct packed {
      logic brk;
      logic fe;
      logic pe;
   } rxf_flags_t;

   localparam rxf_flags_t RXF_NONE = '{brk: 1'b0, fe: 1'b0, pe: 1'b0};
endpackage

// File: rtl/rx_err_fifo_store.sv
module rx_err_fifo_store
   import rx_err_fifo_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   input  rxf_flags_t        wflags,
   output logic [DATA_W-1:0] head_data,
   output rxf_flags_t        head_flags,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem_d [DEPTH];
   rxf_flags_t        mem_f [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [CW-1:0]     count;

   // one register slot per entry, written only when the write pointer selects it
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_d[i] <= '0;
            mem_f[i] <= RXF_NONE;
         end else if (push && !clr && (wr_ptr == AW'(i))) begin
            mem_d[i] <= wdata;
            mem_f[i] <= wflags;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_data  = mem_d[rd_ptr];
   assign head_flags = mem_f[rd_ptr];
   assign full       = (count == CW'(DEPTH));
   assign empty      = (count == '0);
endmodule

// File: rtl/rx_err_fifo_flags.sv
module rx_err_fifo_flags
   import rx_err_fifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       err_clr,
   input  logic       accept,
   input  rxf_flags_t new_flags,
   input  logic       lost,
   output rxf_flags_t accum,
   output logic       ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accum <= RXF_NONE;
         ovr   <= 1'b0;
      end else if (clr) begin
         accum <= RXF_NONE;
         ovr   <= 1'b0;
      end else begin
         // entering flags are merged even in the cycle of an error clear
         if (err_clr)     accum <= accept ? new_flags : RXF_NONE;
         else if (accept) accum <= accum | new_flags;
         if (err_clr)     ovr <= 1'b0;
         else if (lost)   ovr <= 1'b1;
      end
   end
endmodule

// File: rtl/rx_err_fifo_rts.sv
module rx_err_fifo_rts (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic auto_en,
   input  logic start_det,
   input  logic full,
   output logic rtsn
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rtsn <= 1'b0;
      else if (clr || !auto_en)     rtsn <= 1'b0;
      else if (start_det && full)   rtsn <= 1'b1;
      else if (!full)               rtsn <= 1'b0;
   end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
   import rx_err_fifo_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_rst,
   input  logic              err_clr,
   input  logic              blk_mode,
   input  logic              auto_rts,
   input  logic              chr_vld,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_brk,
   input  logic              chr_fe,
   input  logic              chr_pe,
   input  logic              start_det,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data,
   output logic [7:0]        stat,
   output logic              rtsn
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_err_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("rx_err_fifo: DATA_W must be between 5 and 9");
   end

   rxf_flags_t        in_flags, head_flags, accum, shown;
   logic [DATA_W-1:0] head_data;
   logic              full, empty, accept, pop, lost, ovr;

   assign in_flags = '{brk: chr_brk, fe: chr_fe, pe: chr_pe};
   assign accept   = chr_vld && !full && !rx_rst;
   assign lost     = chr_vld && full;
   assign pop      = rd_stb && !empty && !rx_rst;

   rx_err_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (rx_rst),
      .push       (accept),
      .pop        (pop),
      .wdata      (chr_data),
      .wflags     (in_flags),
      .head_data  (head_data),
      .head_flags (head_flags),
      .full       (full),
      .empty      (empty)
   );

   rx_err_fifo_flags i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_rst),
      .err_clr   (err_clr),
      .accept    (accept),
      .new_flags (in_flags),
      .lost      (lost),
      .accum     (accum),
      .ovr       (ovr)
   );

   rx_err_fifo_rts i_rts (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_rst),
      .auto_en   (auto_rts),
      .start_det (start_det),
      .full      (full),
      .rtsn      (rtsn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_data <= '0;
      else if (pop) rd_data <= head_data;
   end

   always_comb begin
      if (blk_mode)   shown = accum;
      else if (empty) shown = RXF_NONE;
      else            shown = head_flags;
   end

   assign stat = {shown.brk, shown.fe, shown.pe, ovr, 2'b00, full, !empty};
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_rst,
   input logic              err_clr,
   input logic              blk_mode,
   input logic              auto_rts,
   input logic              chr_vld,
   input logic              start_det,
   input logic              rd_stb,
   input logic [DATA_W-1:0] rd_data,
   input logic [7:0]        stat,
   input logic              rtsn
);
   p_full_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] |-> stat[0]);

   p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_vld && stat[1] && !rx_rst && !err_clr) |=> stat[4]);

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[4] && !err_clr && !rx_rst) |=> stat[4]);

   p_blk_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_mode && !err_clr && !rx_rst) |=>
      (!blk_mode || ((stat[7:5] & $past(stat[7:5])) == $past(stat[7:5]))));

   p_rts_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rtsn) |-> $past(start_det && stat[1] && auto_rts));

   p_rts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rtsn && stat[1] && auto_rts && !rx_rst) |=> rtsn);

   p_rx_rst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> (stat == 8'h00 && !rtsn));

   p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat[0] && rd_stb) |=> $stable(rd_data));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_rst    (rx_rst),
   .err_clr   (err_clr),
   .blk_mode  (blk_mode),
   .auto_rts  (auto_rts),
   .chr_vld   (chr_vld),
   .start_det (start_det),
   .rd_stb    (rd_stb),
   .rd_data   (rd_data),
   .stat      (stat),
   .rtsn      (rtsn)
);

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_rst = 1'b0, err_clr = 1'b0, blk_mode = 1'b0, auto_rts = 1'b0;
   logic       chr_vld = 1'b0, chr_brk = 1'b0, chr_fe = 1'b0, chr_pe = 1'b0;
   logic       start_det = 1'b0, rd_stb = 1'b0;
   logic [7:0] chr_data = 8'h00;
   logic [7:0] rd_data, stat;
   logic       rtsn;
   int         checks = 0, errors = 0;

   always #2 clk = ~clk;

   rx_err_fifo i_rx_err_fifo (
      .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .err_clr(err_clr),
      .blk_mode(blk_mode), .auto_rts(auto_rts), .chr_vld(chr_vld),
      .chr_data(chr_data), .chr_brk(chr_brk), .chr_fe(chr_fe), .chr_pe(chr_pe),
      .start_det(start_det), .rd_stb(rd_stb), .rd_data(rd_data), .stat(stat),
      .rtsn(rtsn)
   );

   // {brk, fe, pe, data}
   localparam logic [10:0] VEC [8] = '{
      {3'b000, 8'h11}, {3'b001, 8'h22}, {3'b010, 8'h33}, {3'b100, 8'h44},
      {3'b000, 8'h55}, {3'b011, 8'h66}, {3'b000, 8'h77}, {3'b101, 8'h88}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic push(input logic [7:0] d, input logic [2:0] f);
      chr_vld = 1'b1; chr_data = d; {chr_brk, chr_fe, chr_pe} = f;
      tick();
      chr_vld = 1'b0; {chr_brk, chr_fe, chr_pe} = 3'b000;
   endtask

   task automatic pop();
      rd_stb = 1'b1; tick(); rd_stb = 1'b0;
   endtask

   task automatic pulse_start();
      start_det = 1'b1; tick(); start_det = 1'b0;
   endtask

   task automatic pulse_rx_rst();
      rx_rst = 1'b1; tick(); rx_rst = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      check("R5 reset stat", stat, 8'h00);
      check("R5 reset rtsn", {7'b0, rtsn}, 8'h00);
      rst_n = 1'b1;
      tick();

      // table walk: fill in per-character mode
      for (int i = 0; i < 8; i++) push(VEC[i][7:0], VEC[i][10:8]);
      check("R6 R7 full layout", stat, 8'h03);
      auto_rts = 1'b1;
      pulse_start();
      check("R9 rtsn on start while full", {7'b0, rtsn}, 8'h01);
      push(8'h99, 3'b111);
      check("R8 overrun set", stat, 8'h13);
      for (int i = 0; i < 8; i++) begin
         check("R2 head flags", {5'b0, stat[7:5]}, {5'b0, VEC[i][10:8]});
         pop();
         check("R1 read order", rd_data, VEC[i][7:0]);
         if (i == 0) begin
            check("R10 rtsn held on pop edge", {7'b0, rtsn}, 8'h01);
            tick();
            check("R10 rtsn released", {7'b0, rtsn}, 8'h00);
         end
      end
      check("R2 R8 drained stat", stat, 8'h10);

      // empty read
      pop();
      check("R11 empty read data", rd_data, 8'h88);
      check("R11 empty read stat", stat, 8'h10);
      push(8'h5A, 3'b000);
      pop();
      check("R11 next byte after empty read", rd_data, 8'h5A);

      err_clr = 1'b1; tick(); err_clr = 1'b0;
      check("R4 error clear", stat, 8'h00);

      pulse_start();
      check("R9 start while not full", {7'b0, rtsn}, 8'h00);

      // block mode
      blk_mode = 1'b1;
      push(8'hA1, 3'b000);
      push(8'hA2, 3'b010);
      push(8'hA3, 3'b000);
      check("R3 block or", {5'b0, stat[7:5]}, 8'h02);
      blk_mode = 1'b0; #1;
      check("R2 char mode head clean", {5'b0, stat[7:5]}, 8'h00);
      blk_mode = 1'b1; #1;
      for (int i = 0; i < 3; i++) pop();
      check("R3 persists after drain", stat, 8'h40);
      check("R1 block read", rd_data, 8'hA3);
      err_clr = 1'b1; chr_vld = 1'b1; chr_data = 8'hB1; chr_brk = 1'b1;
      tick();
      err_clr = 1'b0; chr_vld = 1'b0; chr_brk = 1'b0;
      check("R4 clear with same-cycle char", stat, 8'h81);
      pop();
      check("R3 R4 after read", stat, 8'h80);
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      blk_mode = 1'b0;

      // receiver reset
      for (int i = 0; i < 9; i++) push(8'hC0 + 8'(i), 3'b001);
      pulse_start();
      check("R9 rtsn before rx reset", {7'b0, rtsn}, 8'h01);
      pulse_rx_rst();
      check("R5 rx reset stat", stat, 8'h00);
      check("R5 rx reset rtsn", {7'b0, rtsn}, 8'h00);
      push(8'hC3, 3'b000);
      pop();
      check("R5 R1 after rx reset", rd_data, 8'hC3);

      // auto rts disable
      for (int i = 0; i < 8; i++) push(8'hD0 + 8'(i), 3'b000);
      pulse_start();
      check("R9 rtsn set again", {7'b0, rtsn}, 8'h01);
      auto_rts = 1'b0;
      tick();
      check("R10 rtsn off when disabled", {7'b0, rtsn}, 8'h00);
      check("R7 still full", stat, 8'h03);
      pulse_rx_rst();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule